// File: doc/BRIEF.md
# Segment Table Address Translator

This block translates a virtual address in a segmented memory scheme into a physical address. The upper bits of the virtual address select one entry of an on-chip segment table. The lower bits are an offset into that segment. Each table entry holds a physical base address, a length limit, a set of access rights and a present flag. The translator adds the offset to the base to form the physical address. At the same time it checks that the segment is resident, that the offset lies within the segment and that the kind of access is allowed.

Software or a management agent loads the table through a single write port, one entry per cycle. A requester presents a virtual address and an access kind with a valid strobe. One cycle later the block returns either a physical address or a fault code. When an access breaks more than one rule, only one fault kind is reported, chosen by a fixed priority.

Top module: `seg_xlat`

## Requirements
- R1: The virtual address `req_va` is split into two fields. Its upper SEG_W bits form the segment number and its lower DISP_W bits form the offset.
- R2: When `wr_en` is high at a clock edge, the entry selected by `wr_seg` takes `wr_present`, `wr_rights`, `wr_len` and `wr_base`. Every later lookup of that segment uses these values.
- R3: A lookup with no fault returns `res_pa` equal to base plus offset, kept to the low PA_W bits (the sum wraps around).
- R4: A lookup of an entry whose present flag is 0 returns `res_fault` = 1 (missing segment). Reset clears the present flag of every entry.
- R5: A lookup whose offset is greater than the entry's length limit returns `res_fault` = 2 (overflow). An offset equal to the limit is in range.
- R6: `req_kind` encodes the access as follows: 0 = read, 1 = write, 2 = execute, 3 = reserved. Kinds 0, 1 and 2 need bits 0, 1 and 2 of the rights field set. A cleared rights bit, or kind 3, gives `res_fault` = 3 (protection violation).
- R7: Fault priority runs from missing segment, to overflow, to protection. Only the highest-priority fault is reported.
- R8: `res_valid` is high in the cycle after a cycle in which `req_valid` was high, and low otherwise.
- R9: `res_pa` is 0 whenever `res_fault` is non-zero or `res_valid` is low. `res_fault` is 0 (no fault) whenever `res_valid` is low.
- R10: A table write and a lookup of the same entry at the same clock edge return the entry contents from before the write.
- R11: While reset is held and after it is released, `res_valid`, `res_pa` and `res_fault` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Table write strobe |
| wr_seg | input | SEG_W | Entry to write |
| wr_present | input | 1 | Present flag to store |
| wr_rights | input | 3 | Rights to store (bit 0 read, bit 1 write, bit 2 execute) |
| wr_len | input | DISP_W | Largest legal offset for the segment |
| wr_base | input | PA_W | Physical base address of the segment |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | SEG_W+DISP_W | Virtual address: segment number above the offset |
| req_kind | input | 2 | Access kind (0 read, 1 write, 2 execute, 3 reserved) |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| res_pa | output | PA_W | Physical address, 0 on a fault |
| res_fault | output | 2 | 0 none, 1 missing, 2 overflow, 3 protection |

## Verification
The bench builds the translator with a 4-bit segment number, a 12-bit offset and a 16-bit physical address. This makes a 16-entry table. With these widths the lowest and highest segment numbers and the all-ones offset can be reached in a few cycles. A base near the top of the physical space makes the address sum wrap, so the truncation can be seen. Limits of 0 and of the full offset range test both ends of the length comparison. A write and a lookup of one entry in the same cycle show which contents the lookup returns.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

   localparam int RIGHTS_W = 3;
   localparam int KIND_W   = 2;

   typedef enum logic [1:0] {
      FLT_NONE     = 2'd0,
      FLT_MISSING  = 2'd1,
      FLT_OVERFLOW = 2'd2,
      FLT_PROTECT  = 2'd3
   } seg_fault_e;

   typedef enum logic [KIND_W-1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_EXEC  = 2'd2,
      ACC_RSVD  = 2'd3
   } seg_access_e;

endpackage

// File: rtl/seg_table.sv
module seg_table
   import seg_xlat_pkg::*;
#(
   parameter int SEG_W  = 8,
   parameter int DISP_W = 24,
   parameter int PA_W   = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [SEG_W-1:0]    wr_idx,
   input  logic                wr_present,
   input  logic [RIGHTS_W-1:0] wr_rights,
   input  logic [DISP_W-1:0]   wr_len,
   input  logic [PA_W-1:0]     wr_base,
   input  logic                rd_en,
   input  logic [SEG_W-1:0]    rd_idx,
   output logic                rd_present,
   output logic [RIGHTS_W-1:0] rd_rights,
   output logic [DISP_W-1:0]   rd_len,
   output logic [PA_W-1:0]     rd_base
);

   localparam int DEPTH = 1 << SEG_W;

   // The present flags sit in resettable flops, one per entry. The other fields are plain storage.
   logic [DEPTH-1:0]    present_q;
   logic [RIGHTS_W-1:0] rights_mem [DEPTH];
   logic [DISP_W-1:0]   len_mem    [DEPTH];
   logic [PA_W-1:0]     base_mem   [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_present
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            present_q[e] <= 1'b0;
         end else if (wr_en && (wr_idx == SEG_W'(e))) begin
            present_q[e] <= wr_present;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         rights_mem[wr_idx] <= wr_rights;
         len_mem[wr_idx]    <= wr_len;
         base_mem[wr_idx]   <= wr_base;
      end
   end

   // The read registers sample the arrays at the same edge as the write. They therefore get the contents from before the write.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_present <= 1'b0;
      end else if (rd_en) begin
         rd_present <= present_q[rd_idx];
      end
   end

   always_ff @(posedge clk) begin
      if (rd_en) begin
         rd_rights <= rights_mem[rd_idx];
         rd_len    <= len_mem[rd_idx];
         rd_base   <= base_mem[rd_idx];
      end
   end

endmodule

// File: rtl/seg_fault_check.sv
module seg_fault_check
   import seg_xlat_pkg::*;
#(
   parameter int DISP_W = 24
) (
   input  logic                present,
   input  logic [RIGHTS_W-1:0] rights,
   input  logic [DISP_W-1:0]   limit,
   input  logic [DISP_W-1:0]   disp,
   input  logic [KIND_W-1:0]   kind,
   output seg_fault_e          fault
);

   localparam int NKIND = 1 << KIND_W;

   logic [NKIND-1:0] allow;

   // Each access kind has its own rights bit. A kind with no rights bit is never allowed.
   for (genvar k = 0; k < NKIND; k++) begin : g_allow
      if (k < RIGHTS_W) begin : g_mapped
         assign allow[k] = rights[k];
      end else begin : g_reserved
         assign allow[k] = 1'b0;
      end
   end

   logic beyond;
   assign beyond = disp > limit;

   always_comb begin
      if (!present) begin
         fault = FLT_MISSING;
      end else if (beyond) begin
         fault = FLT_OVERFLOW;
      end else if (!allow[kind]) begin
         fault = FLT_PROTECT;
      end else begin
         fault = FLT_NONE;
      end
   end

endmodule

// File: rtl/seg_pa_adder.sv
module seg_pa_adder #(
   parameter int DISP_W = 24,
   parameter int PA_W   = 32
) (
   input  logic [PA_W-1:0]   base,
   input  logic [DISP_W-1:0] disp,
   output logic [PA_W-1:0]   pa
);

   logic [PA_W-1:0] disp_ext;

   if (PA_W > DISP_W) begin : g_widen
      assign disp_ext = {{(PA_W-DISP_W){1'b0}}, disp};
   end else begin : g_same
      assign disp_ext = disp;
   end

   // Any carry out of the top bit is dropped, so the sum wraps.
   assign pa = base + disp_ext;

endmodule

// File: rtl/seg_xlat.sv
module seg_xlat
   import seg_xlat_pkg::*;
#(
   parameter int SEG_W  = 8,
   parameter int DISP_W = 24,
   parameter int PA_W   = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [SEG_W-1:0]        wr_seg,
   input  logic                    wr_present,
   input  logic [2:0]              wr_rights,
   input  logic [DISP_W-1:0]       wr_len,
   input  logic [PA_W-1:0]         wr_base,
   input  logic                    req_valid,
   input  logic [SEG_W+DISP_W-1:0] req_va,
   input  logic [1:0]              req_kind,
   output logic                    res_valid,
   output logic [PA_W-1:0]         res_pa,
   output logic [1:0]              res_fault
);

   localparam int VA_W = SEG_W + DISP_W;

   if (SEG_W < 1 || SEG_W > 12) begin : g_bad_seg
      $error("seg_xlat: SEG_W must lie in 1..12");
   end
   if (DISP_W < 1) begin : g_bad_disp
      $error("seg_xlat: DISP_W must be positive");
   end
   if (PA_W < DISP_W) begin : g_bad_pa
      $error("seg_xlat: PA_W must not be narrower than DISP_W");
   end
   if (RIGHTS_W != 3 || KIND_W != 2) begin : g_bad_pkg
      $error("seg_xlat: port widths assume three rights bits and a two-bit kind");
   end

   logic [SEG_W-1:0]  va_seg;
   logic [DISP_W-1:0] va_disp;
   assign va_seg  = req_va[VA_W-1:DISP_W];
   assign va_disp = req_va[DISP_W-1:0];

   logic                valid_q;
   logic [DISP_W-1:0]   disp_q;
   logic [KIND_W-1:0]   kind_q;
   logic                ent_present;
   logic [RIGHTS_W-1:0] ent_rights;
   logic [DISP_W-1:0]   ent_len;
   logic [PA_W-1:0]     ent_base;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
      end else begin
         valid_q <= req_valid;
      end
   end

   always_ff @(posedge clk) begin
      if (req_valid) begin
         disp_q <= va_disp;
         kind_q <= req_kind;
      end
   end

   seg_table #(.SEG_W(SEG_W), .DISP_W(DISP_W), .PA_W(PA_W)) u_table (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_idx     (wr_seg),
      .wr_present (wr_present),
      .wr_rights  (wr_rights),
      .wr_len     (wr_len),
      .wr_base    (wr_base),
      .rd_en      (req_valid),
      .rd_idx     (va_seg),
      .rd_present (ent_present),
      .rd_rights  (ent_rights),
      .rd_len     (ent_len),
      .rd_base    (ent_base)
   );

   seg_fault_e      fault_c;
   logic [PA_W-1:0] sum_c;

   seg_fault_check #(.DISP_W(DISP_W)) u_check (
      .present (ent_present),
      .rights  (ent_rights),
      .limit   (ent_len),
      .disp    (disp_q),
      .kind    (kind_q),
      .fault   (fault_c)
   );

   seg_pa_adder #(.DISP_W(DISP_W), .PA_W(PA_W)) u_add (
      .base (ent_base),
      .disp (disp_q),
      .pa   (sum_c)
   );

   assign res_valid = valid_q;
   assign res_fault = valid_q ? fault_c : FLT_NONE;
   assign res_pa    = (valid_q && fault_c == FLT_NONE) ? sum_c : '0;

endmodule

// File: rtl/seg_xlat_chk.sv
module seg_xlat_chk #(
   parameter int SEG_W  = 8,
   parameter int DISP_W = 24,
   parameter int PA_W   = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              res_valid,
   input logic [PA_W-1:0]   res_pa,
   input logic [1:0]        res_fault,
   input logic              ent_present,
   input logic [DISP_W-1:0] ent_len,
   input logic [DISP_W-1:0] disp_q
);

   // R8
   a_r8_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> res_valid);

   // R8
   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !res_valid);

   // R9
   a_r9_idle_outputs_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> (res_fault == 2'd0 && res_pa == '0));

   // R9
   a_r9_pa_zero_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_fault != 2'd0) |-> res_pa == '0);

   // R4, R7
   a_r4_missing_first: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !ent_present) |-> res_fault == 2'd1);

   // R5, R7
   a_r5_overflow_second: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && ent_present && disp_q > ent_len) |-> res_fault == 2'd2);

endmodule

bind seg_xlat seg_xlat_chk #(.SEG_W(SEG_W), .DISP_W(DISP_W), .PA_W(PA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .res_valid   (res_valid),
   .res_pa      (res_pa),
   .res_fault   (res_fault),
   .ent_present (ent_present),
   .ent_len     (ent_len),
   .disp_q      (disp_q)
);

// File: tb/seg_xlat_test.sv
`timescale 1ns/1ps
module seg_xlat_test;

   localparam int SW = 4;
   localparam int DW = 12;
   localparam int PW = 16;
   localparam int NSEG = 1 << SW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [SW-1:0] wr_seg = '0;
   logic          wr_present = 1'b0;
   logic [2:0]    wr_rights = '0;
   logic [DW-1:0] wr_len = '0;
   logic [PW-1:0] wr_base = '0;
   logic          req_valid = 1'b0;
   logic [SW+DW-1:0] req_va = '0;
   logic [1:0]    req_kind = '0;
   logic          res_valid;
   logic [PW-1:0] res_pa;
   logic [1:0]    res_fault;

   always #4 clk = ~clk;

   seg_xlat #(.SEG_W(SW), .DISP_W(DW), .PA_W(PW)) uut (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_seg(wr_seg), .wr_present(wr_present),
      .wr_rights(wr_rights), .wr_len(wr_len), .wr_base(wr_base),
      .req_valid(req_valid), .req_va(req_va), .req_kind(req_kind),
      .res_valid(res_valid), .res_pa(res_pa), .res_fault(res_fault)
   );

   int n_chk = 0;
   int n_fail = 0;

   // Bench's own view of the table
   logic          m_pres  [NSEG];
   logic [2:0]    m_rights[NSEG];
   logic [DW-1:0] m_len   [NSEG];
   logic [PW-1:0] m_base  [NSEG];

   typedef struct {
      logic [PW-1:0] pa;
      logic [1:0]    fault;
      string         tag;
   } exp_t;
   exp_t sb[$];

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [PW-1:0] act, input logic [PW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic exp_t predict(input logic [SW-1:0] s, input logic [DW-1:0] d,
                                    input logic [1:0] k, input string tag);
      exp_t e;
      e.tag = tag;
      e.pa = '0;
      if (!m_pres[s])            e.fault = 2'd1;
      else if (d > m_len[s])     e.fault = 2'd2;
      else if (k == 2'd3 || !m_rights[s][k]) e.fault = 2'd3;
      else begin
         e.fault = 2'd0;
         e.pa = m_base[s] + PW'(d);
      end
      return e;
   endfunction

   // Driver: one cycle of stimulus, an optional write and an optional lookup
   task automatic cycle(input bit we, input logic [SW-1:0] ws, input bit wp,
                        input logic [2:0] wrt, input logic [DW-1:0] wl, input logic [PW-1:0] wb,
                        input bit rv, input logic [SW-1:0] rs, input logic [DW-1:0] rd,
                        input logic [1:0] rk, input string tag);
      @(negedge clk);
      wr_en = we; wr_seg = ws; wr_present = wp; wr_rights = wrt; wr_len = wl; wr_base = wb;
      req_valid = rv; req_va = {rs, rd}; req_kind = rk;
      if (rv) sb.push_back(predict(rs, rd, rk, tag));
      if (we) begin
         m_pres[ws] = wp; m_rights[ws] = wrt; m_len[ws] = wl; m_base[ws] = wb;
      end
   endtask

   task automatic put(input logic [SW-1:0] s, input bit p, input logic [2:0] r,
                      input logic [DW-1:0] l, input logic [PW-1:0] b);
      cycle(1'b1, s, p, r, l, b, 1'b0, '0, '0, 2'd0, "");
   endtask

   task automatic look(input logic [SW-1:0] s, input logic [DW-1:0] d,
                       input logic [1:0] k, input string tag);
      cycle(1'b0, '0, 1'b0, '0, '0, '0, 1'b1, s, d, k, tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cycle(1'b0, '0, 1'b0, '0, '0, '0, 1'b0, '0, '0, 2'd0, "");
   endtask

   // Monitor: compare each result with the oldest expectation
   always @(negedge clk) begin
      if (rst_n && res_valid) begin
         if (sb.size() == 0) begin
            check(1'b0, "R8", "result without request", {15'd0, res_valid}, '0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(res_fault == e.fault, e.tag, "fault", PW'(res_fault), PW'(e.fault));
            check(res_pa == e.pa, e.tag, "pa (R9 when faulted)", res_pa, e.pa);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      for (int i = 0; i < NSEG; i++) begin
         m_pres[i] = 1'b0; m_rights[i] = '0; m_len[i] = '0; m_base[i] = '0;
      end
      repeat (3) @(negedge clk);
      // R11: outputs quiet while reset is held
      check(res_valid == 0 && res_pa == 0 && res_fault == 0, "R11", "in reset",
            {res_pa[PW-1:3], res_fault, res_valid}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check(res_valid == 0 && res_pa == 0 && res_fault == 0, "R11", "after reset",
            {res_pa[PW-1:3], res_fault, res_valid}, '0);

      look(4'd5, 12'h000, 2'd0, "R4 unwritten after reset");

      put(4'd1, 1'b1, 3'b111, 12'h100, 16'h2000);
      look(4'd1, 12'h000, 2'd0, "R3 base only");
      look(4'd1, 12'h100, 2'd1, "R5 offset at limit");
      look(4'd1, 12'h101, 2'd0, "R5 offset past limit");

      put(4'd2, 1'b1, 3'b001, 12'hFFF, 16'hFF00);
      look(4'd2, 12'h1F0, 2'd0, "R3 wrapped sum");
      look(4'd2, 12'h010, 2'd1, "R6 write denied");
      look(4'd2, 12'h010, 2'd2, "R6 execute denied");
      look(4'd2, 12'h010, 2'd3, "R6 reserved kind");

      put(4'd6, 1'b1, 3'b100, 12'h0FF, 16'h0800);
      look(4'd6, 12'h0FF, 2'd2, "R6 execute granted");
      look(4'd6, 12'h0FF, 2'd0, "R6 read denied");

      put(4'd3, 1'b0, 3'b000, 12'h004, 16'h1000);
      look(4'd3, 12'h800, 2'd3, "R7 missing over all");
      put(4'd4, 1'b1, 3'b000, 12'h010, 16'h1000);
      look(4'd4, 12'h020, 2'd1, "R7 overflow over protect");

      put(4'd15, 1'b1, 3'b111, 12'hFFF, 16'h0001);
      put(4'd0, 1'b1, 3'b111, 12'h000, 16'h4000);
      look(4'd15, 12'hFFF, 2'd0, "R1 top segment all-ones offset");
      look(4'd0, 12'h000, 2'd2, "R1 segment zero");
      look(4'd0, 12'h001, 2'd0, "R1 R5 zero limit");

      // R10: write and lookup of segment 1 in the same cycle
      cycle(1'b1, 4'd1, 1'b1, 3'b111, 12'h100, 16'h3000, 1'b1, 4'd1, 12'h004, 2'd0, "R10 old contents");
      look(4'd1, 12'h004, 2'd0, "R2 new contents");
      put(4'd1, 1'b0, 3'b111, 12'h100, 16'h3000);
      look(4'd1, 12'h004, 2'd0, "R2 R4 cleared present");

      idle(2);
      // R8: no result after idle cycles
      check(res_valid == 1'b0, "R8", "idle valid", {15'd0, res_valid}, '0);
      idle(2);
      check(sb.size() == 0, "R8", "pending results", PW'(sb.size()), '0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule